// File: doc/BRIEF.md
# Dual-Mode Encoder Length Controller

This block turns one endless rotary encoder, its push-button and a signed control-voltage sample into the stage count of a variable pipeline from 1 to 64. It holds two settings. The first is the base length. The second is a modulation depth in percent. A debounced press of the button selects which of the two settings the encoder changes. A two-digit display value and a dot show the user which setting is being edited.

The raw A/B encoder lines are synchronised and decoded inside the block, at one count for each valid Gray-code transition. The CV sample is an 8-bit two's-complement value. The depth scales it, and the result is added to the base, so the CV can move the length up or down. The sum is clamped to 1..64 and registered before it leaves the block.

Top module: `enc_len_ctrl`

## Requirements
- R1: After reset the base is 16, the depth is 0 and the editing mode is base mode. So `disp_val` = 16, `disp_dot` = 0 and `eff_len` = 16.
- R2: In base mode, a forward transition of the synchronised {A,B} pair raises the base by 1. The forward transitions are 00→01, 01→11, 11→10 and 10→00. The reverse transition lowers the base by 1. Without a transition or a press, `disp_val` holds.
- R3: The base saturates at 64 going up and at 1 going down. It never wraps.
- R4: A debounced press toggles the mode. In depth mode `disp_dot` = 1 and `disp_val` shows the depth. In base mode `disp_dot` = 0 and `disp_val` shows the base.
- R5: In depth mode, encoder steps change the depth by 1 per transition, saturating at 0 and 99. While in depth mode the base is left unchanged.
- R6: A level on the button is taken only after it has differed from the debounced state for 16 consecutive clock samples. Shorter bounces cause no toggle. One held press gives exactly one toggle.
- R7: `eff_len` = clamp(base + off, 1, 64). Here off = n·64/12800 rounded to the nearest integer with halves rounded away from zero, and n = cv·depth. `eff_len` is registered and follows a CV change after one clock edge.
- R8: `eff_len` always lies in 1..64, even at full-scale CV of either sign and depth 99.
- R9: A change of both A and B at once is not a valid transition. It changes neither the base nor the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| enc_btn | input | 1 | Raw encoder push-button, high when pressed |
| cv | input | 8 | Signed CV sample (two's complement) |
| eff_len | output | 7 | Registered effective pipeline length, 1..64 |
| disp_val | output | 7 | Value to display: base or depth |
| disp_dot | output | 1 | Dot lit while the depth is being edited |

## Verification
A wrong step count or saturation limit in the setting registers reaches `disp_val` within about three clocks of the encoder transition, because the display is driven straight from the stored settings. A mode flip-flop that toggles on a bounce, or fails to toggle, shows at once on `disp_dot`. It also shows as the display switching between base and depth. Errors in the scaling or rounding of the CV appear on `eff_len` one clock after the CV changes. The rounding corners at an offset of exactly ±0.5 and the two clamp limits are driven on purpose.

// File: rtl/enc_len_pkg.sv
package enc_len_pkg;
  typedef enum logic {
    EDIT_BASE  = 1'b0,
    EDIT_DEPTH = 1'b1
  } edit_mode_e;
endpackage

// File: rtl/quad_step_dec.sv
module quad_step_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic enc_a,
  input  logic enc_b,
  output logic step_up,
  output logic step_dn
);
  logic [1:0] a_sync, b_sync;
  logic [1:0] ab_prev;
  logic [1:0] ab_cur;

  // forward neighbour in the Gray cycle 00 -> 01 -> 11 -> 10 -> 00
  function automatic logic [1:0] gray_fwd(input logic [1:0] s);
    case (s)
      2'b00:   return 2'b01;
      2'b01:   return 2'b11;
      2'b11:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  assign ab_cur  = {a_sync[1], b_sync[1]};
  assign step_up = (ab_cur == gray_fwd(ab_prev));
  assign step_dn = (ab_prev == gray_fwd(ab_cur));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sync  <= '0;
      b_sync  <= '0;
      ab_prev <= '0;
    end else begin
      a_sync  <= {a_sync[0], enc_a};
      b_sync  <= {b_sync[0], enc_b};
      ab_prev <= ab_cur;
    end
  end
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic press
);
  localparam int CNT_W = $clog2(DEB_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

  logic [1:0]       btn_sync;
  logic             btn_stable;
  logic [CNT_W-1:0] diff_cnt;
  logic             accept;

  assign accept = (btn_sync[1] != btn_stable) && (diff_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_sync   <= '0;
      btn_stable <= 1'b0;
      diff_cnt   <= '0;
      press      <= 1'b0;
    end else begin
      btn_sync <= {btn_sync[0], btn_raw};
      press    <= accept && btn_sync[1];
      if (btn_sync[1] == btn_stable) begin
        diff_cnt <= '0;
      end else if (accept) begin
        btn_stable <= btn_sync[1];
        diff_cnt   <= '0;
      end else begin
        diff_cnt <= diff_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/setting_store.sv
module setting_store
  import enc_len_pkg::*;
#(
  parameter int LEN_W     = 7,
  parameter int DEP_W     = 7,
  parameter int LEN_MIN   = 1,
  parameter int LEN_MAX   = 64,
  parameter int DEPTH_MAX = 99,
  parameter int BASE_RST  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             press,
  output edit_mode_e       mode,
  output logic [LEN_W-1:0] base_len,
  output logic [DEP_W-1:0] depth
);
  // saturating +/-1 on an int value
  function automatic int sat_step(input int v, input logic up, input logic dn,
                                  input int lo, input int hi);
    if (up && v < hi) return v + 1;
    if (dn && v > lo) return v - 1;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= EDIT_BASE;
      base_len <= LEN_W'(BASE_RST);
      depth    <= '0;
    end else begin
      if (press) mode <= (mode == EDIT_BASE) ? EDIT_DEPTH : EDIT_BASE;
      if (mode == EDIT_BASE)
        base_len <= LEN_W'(sat_step(int'(base_len), step_up, step_dn, LEN_MIN, LEN_MAX));
      else
        depth <= DEP_W'(sat_step(int'(depth), step_up, step_dn, 0, DEPTH_MAX));
    end
  end
endmodule

// File: rtl/len_mod_calc.sv
module len_mod_calc #(
  parameter int LEN_W     = 7,
  parameter int DEP_W     = 7,
  parameter int CV_W      = 8,
  parameter int LEN_MIN   = 1,
  parameter int LEN_MAX   = 64,
  parameter int BASE_RST  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LEN_W-1:0]       base_len,
  input  logic [DEP_W-1:0]       depth,
  input  logic signed [CV_W-1:0] cv,
  output logic [LEN_W-1:0]       eff_len
);
  // full-scale CV times 100 percent spans the whole length range
  localparam int DEN = (2 ** (CV_W - 1)) * 100;

  function automatic int mod_offset(input int n);
    int mag;
    int q;
    mag = (n < 0) ? -n : n;
    q   = (mag * LEN_MAX + DEN / 2) / DEN;
    return (n < 0) ? -q : q;
  endfunction

  function automatic int clamp_len(input int v);
    if (v < LEN_MIN) return LEN_MIN;
    if (v > LEN_MAX) return LEN_MAX;
    return v;
  endfunction

  int sum_len;
  always_comb sum_len = int'(base_len) + mod_offset(int'(cv) * int'(depth));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_len <= LEN_W'(BASE_RST);
    else        eff_len <= LEN_W'(clamp_len(sum_len));
  end
endmodule

// File: rtl/enc_len_ctrl.sv
module enc_len_ctrl
  import enc_len_pkg::*;
#(
  parameter int LEN_MIN   = 1,
  parameter int LEN_MAX   = 64,
  parameter int DEPTH_MAX = 99,
  parameter int BASE_RST  = 16,
  parameter int DEB_CYC   = 16,
  parameter int CV_W      = 8,
  localparam int LEN_W    = $clog2(LEN_MAX + 1),
  localparam int DEP_W    = $clog2(DEPTH_MAX + 1),
  localparam int DISP_W   = (LEN_W > DEP_W) ? LEN_W : DEP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enc_a,
  input  logic                   enc_b,
  input  logic                   enc_btn,
  input  logic signed [CV_W-1:0] cv,
  output logic [LEN_W-1:0]       eff_len,
  output logic [DISP_W-1:0]      disp_val,
  output logic                   disp_dot
);
  logic             step_up, step_dn, press;
  edit_mode_e       mode;
  logic [LEN_W-1:0] base_len;
  logic [DEP_W-1:0] depth;

  quad_step_dec u_dec (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .step_up(step_up), .step_dn(step_dn)
  );

  btn_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .btn_raw(enc_btn), .press(press)
  );

  setting_store #(
    .LEN_W(LEN_W), .DEP_W(DEP_W), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX),
    .DEPTH_MAX(DEPTH_MAX), .BASE_RST(BASE_RST)
  ) u_set (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .press(press), .mode(mode), .base_len(base_len), .depth(depth)
  );

  len_mod_calc #(
    .LEN_W(LEN_W), .DEP_W(DEP_W), .CV_W(CV_W), .LEN_MIN(LEN_MIN),
    .LEN_MAX(LEN_MAX), .BASE_RST(BASE_RST)
  ) u_calc (
    .clk(clk), .rst_n(rst_n), .base_len(base_len), .depth(depth),
    .cv(cv), .eff_len(eff_len)
  );

  assign disp_dot = (mode == EDIT_DEPTH);
  assign disp_val = disp_dot ? DISP_W'(depth) : DISP_W'(base_len);
endmodule

// File: rtl/enc_len_chk.sv
module enc_len_chk #(
  parameter int LEN_W     = 7,
  parameter int DISP_W    = 7,
  parameter int LEN_MIN   = 1,
  parameter int LEN_MAX   = 64,
  parameter int DEPTH_MAX = 99
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_up,
  input logic              step_dn,
  input logic              press,
  input logic [LEN_W-1:0]  eff_len,
  input logic [DISP_W-1:0] disp_val,
  input logic              disp_dot
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !press) |=> $stable(disp_val));

  assert_base_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !press && !disp_dot && disp_val < DISP_W'(LEN_MAX))
      |=> disp_val == $past(disp_val) + 1'b1);

  assert_base_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !press && !disp_dot && disp_val == DISP_W'(LEN_MAX))
      |=> disp_val == DISP_W'(LEN_MAX));

  assert_base_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_dot |-> disp_val >= DISP_W'(LEN_MIN));

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> disp_dot != $past(disp_dot));

  assert_depth_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_dot |-> disp_val <= DISP_W'(DEPTH_MAX));

  assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));

  assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_len >= LEN_W'(LEN_MIN)) && (eff_len <= LEN_W'(LEN_MAX)));
endmodule

bind enc_len_ctrl enc_len_chk #(
  .LEN_W(LEN_W), .DISP_W(DISP_W), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX),
  .DEPTH_MAX(DEPTH_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
  .press(press), .eff_len(eff_len), .disp_val(disp_val), .disp_dot(disp_dot)
);

// File: tb/enc_len_ctrl_tb.sv
module enc_len_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_btn = 1'b0;
  logic signed [7:0] cv = '0;
  logic [6:0] eff_len, disp_val;
  logic disp_dot;

  int checks = 0;
  int errors = 0;
  int cur_depth = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  enc_len_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_btn(enc_btn),
    .cv(cv), .eff_len(eff_len), .disp_val(disp_val), .disp_dot(disp_dot)
  );

  // {depth, cv, expected eff_len} with base 16; rounding and clamp corners
  typedef struct packed { logic [7:0] dep; logic signed [7:0] cvv; logic [7:0] exp_len; } vec_t;
  localparam vec_t VECS [8] = '{
    '{8'd0,  8'sd127,  8'd16},
    '{8'd99, 8'sd127,  8'd64},
    '{8'd99, -8'sd128, 8'd1},
    '{8'd50, 8'sd40,   8'd26},
    '{8'd50, -8'sd40,  8'd6},
    '{8'd10, 8'sd10,   8'd17},
    '{8'd10, -8'sd10,  8'd15},
    '{8'd10, 8'sd9,    8'd16}
  };

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic turn(input bit up, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case ({enc_a, enc_b})
        2'b00: {enc_a, enc_b} = up ? 2'b01 : 2'b10;
        2'b01: {enc_a, enc_b} = up ? 2'b11 : 2'b00;
        2'b11: {enc_a, enc_b} = up ? 2'b10 : 2'b01;
        default: {enc_a, enc_b} = up ? 2'b00 : 2'b11;
      endcase
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic hold_btn(input int cyc);
    @(negedge clk);
    enc_btn = 1'b1;
    repeat (cyc) @(negedge clk);
    enc_btn = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic set_depth(input int target);
    if (target > cur_depth) turn(1'b1, target - cur_depth);
    else if (target < cur_depth) turn(1'b0, cur_depth - target);
    cur_depth = target;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 disp_val", int'(disp_val), 16);
    check("R1 disp_dot", int'(disp_dot), 0);
    check("R1 eff_len", int'(eff_len), 16);

    turn(1'b1, 3);  check("R2 up", int'(disp_val), 19);
    turn(1'b0, 5);  check("R2 down", int'(disp_val), 14);
    turn(1'b0, 20); check("R3 floor", int'(disp_val), 1);
    turn(1'b1, 70); check("R3 ceiling", int'(disp_val), 64);
    check("R7 eff follows base", int'(eff_len), 64);
    turn(1'b0, 48); check("R2 back to 16", int'(disp_val), 16);

    // R9: both phases flip together, then flip back
    @(negedge clk); {enc_a, enc_b} = ~{enc_a, enc_b};
    repeat (5) @(negedge clk); {enc_a, enc_b} = ~{enc_a, enc_b};
    repeat (6) @(negedge clk);
    check("R9 double change ignored", int'(disp_val), 16);

    // R6: bounces of 5 cycles do not toggle
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); enc_btn = 1'b1;
      repeat (5) @(negedge clk); enc_btn = 1'b0;
      repeat (5) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check("R6 bounce ignored", int'(disp_dot), 0);
    hold_btn(60);
    check("R6 one toggle per press", int'(disp_dot), 1);
    check("R4 depth shown", int'(disp_val), 0);

    turn(1'b0, 3);   check("R5 depth floor", int'(disp_val), 0);
    turn(1'b1, 120); check("R5 depth ceiling", int'(disp_val), 99);
    cur_depth = 99;

    foreach (VECS[i]) begin
      set_depth(int'(VECS[i].dep));
      @(negedge clk); cv = VECS[i].cvv;
      repeat (3) @(negedge clk);
      check("R7/R8 eff_len vector", int'(eff_len), int'(VECS[i].exp_len));
    end

    // R7 latency: one edge after a CV change
    set_depth(50);
    @(negedge clk); cv = 8'sd0;
    repeat (3) @(negedge clk);
    check("R7 zero cv", int'(eff_len), 16);
    cv = 8'sd40;
    @(negedge clk);
    check("R7 one-cycle update", int'(eff_len), 26);

    hold_btn(40);
    check("R4 dot off", int'(disp_dot), 0);
    check("R5 base unchanged", int'(disp_val), 16);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule